// File: doc/BRIEF.md
# Pipeline hazard stall scoreboard

This block decides, for every instruction issued by a 32-bit in-order core, how many bubble cycles must be inserted before it may proceed. It keeps a short history of which registers the most recent instructions modified, plus a separate history of the registers filled by multi-register loads. Each issued instruction is described by its unit class, its source, destination and address register numbers, the last register index of a multi-register transfer, the transfer address and the low bits of its fetch PC. The scoreboard returns the total stall, keeps one running counter per stall cause and updates its history.

Two marker bits in the 32-bit modified-register mask record events that are not register writes. Bit 16 records a jump and bit 20 records a memory write. Special registers occupy mask indices 16 to 31. The multiply side-result register is index 23. General registers occupy indices 0 to 15. "Previous instruction" always means the last issued instruction. Idle cycles, when nothing issues, do not age the history. Every inserted stall cycle ages it by one position and enters an empty mask.

Top module: `hz_scoreboard`

## Requirements
- R1: Unit class 0 (exec) reads its source when src_use is set and its destination when dst_use is set. A read register that the nearest multi-register load (class 6) filled one, two or three instructions back costs 3, 2 or 1 cycles. The cost is the larger of the two operand costs, and it is counted under cause 0.
- R2: A memory read (class 1) or memory write (class 2) whose address register was modified by the previous instruction costs 1 cycle, counted under cause 1.
- R3: A memory read costs 2 cycles, under cause 2, when either of the two previous instructions was a memory write. A memory write sets mask bit 20.
- R4: A jump-to-register (class 3) costs 2 cycles when its target register (src_reg) was modified by the previous instruction. It costs 1 cycle when the instruction before that modified it, and in both cases the cost goes to cause 3. A jump sets mask bit 16.
- R5: A multiply (class 4) costs 1 cycle, under cause 4, when its source or destination was modified by the previous instruction. A multiply marks its destination and register index 23 as modified.
- R6: A 16-bit immediate fetch (class 7) issued right after a jump costs 1 cycle when fetch_pc_lo (PC bits 4..1) is 4'b1111. A 32-bit immediate fetch (class 8) under the same condition costs 1 cycle when the field is 4'b1110. Both costs go to cause 5.
- R7: A multi-register store (class 5) of registers 0..N costs 2 cycles if the previous instruction modified any of them, otherwise 1 cycle if the instruction before that did. The cost goes to cause 6.
- R8: A multi-register store or load of registers 0..N at address A costs one more cycle for each 32-byte line boundary crossed, (A+4(N+1)-1)>>5 minus A>>5. The cost goes to cause 7, and a load marks registers 0..N as modified and as load-filled.
- R9: Each stall cycle charged to an instruction ages both histories by one extra position before that instruction's own masks enter.
- R10: stall_valid and stall_cycles (the sum of all cause costs) appear one clock after the issuing edge. Cycles without issue_valid leave the history unchanged.
- R11: Each cause counter (cause i at cause_counts bits [i*CNT_W +: CNT_W]) adds that instruction's cost for cause i and saturates at all ones.
- R12: A register write to index 16 or 20 sets no jump or memory-write marker.
- R13: Reset clears both histories, all counters and stall_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_unit | input | 4 | Unit class code 0..8 |
| src_reg | input | 5 | Source register index (jump target for class 3) |
| src_use | input | 1 | Source register is read (class 0) |
| dst_reg | input | 5 | Destination register index |
| dst_use | input | 1 | Destination is read and written (class 0) or written (class 1) |
| addr_reg | input | 5 | Memory address register index |
| last_reg | input | 4 | Highest register N of a multi-register transfer |
| xfer_addr | input | 32 | Start address of a multi-register transfer |
| fetch_pc_lo | input | 4 | PC bits 4..1 of the instruction |
| stall_valid | output | 1 | stall_cycles holds a fresh result |
| stall_cycles | output | 3 | Stall cycles charged to the last issued instruction |
| cause_counts | output | 8*CNT_W | Saturating per-cause stall counters |

## Verification
The bench sweeps the number of filler instructions between a producer and a consumer for every hazard kind: multi-load use, address use, memory read after write, jump target and store source. This separates the 3/2/1 distance costs and shows where each window ends. Fetch PC fields are swept over all sixteen values after a jump and without one, which separates the two immediate sizes and the jump marker. Line crossings are swept over sixteen start offsets and every register count and checked against the arithmetic formula. Targeted sequences then check that stall cycles age the history, that idle cycles do not, that writes to the marker indices are inert, that the narrow test counters saturate, and that reset clears everything.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int MASK_W    = 32;
  localparam int REG_W     = $clog2(MASK_W);
  localparam int JUMP_BIT  = 16;
  localparam int MEMWR_BIT = 20;
  localparam int MOF_BIT   = 23;
  localparam int MOD_DEPTH = 2;
  localparam int LD_DEPTH  = 3;
  localparam int NCAUSE    = 8;
  localparam int COST_W    = 3;

  typedef enum logic [3:0] {
    UC_EXEC     = 4'd0,
    UC_MEM_RD   = 4'd1,
    UC_MEM_WR   = 4'd2,
    UC_JUMP_REG = 4'd3,
    UC_MUL      = 4'd4,
    UC_MSTORE   = 4'd5,
    UC_MLOAD    = 4'd6,
    UC_IMM16    = 4'd7,
    UC_IMM32    = 4'd8
  } hz_unit_e;

  // stall cause slots
  localparam int CZ_LOADUSE = 0;
  localparam int CZ_ADDR    = 1;
  localparam int CZ_RAW     = 2;
  localparam int CZ_JSRC    = 3;
  localparam int CZ_MUL     = 4;
  localparam int CZ_IMMLINE = 5;
  localparam int CZ_MSTORE  = 6;
  localparam int CZ_XLINE   = 7;

  typedef logic [NCAUSE-1:0][COST_W-1:0] hz_cost_t;
  typedef logic [MASK_W-1:0]             hz_mask_t;
endpackage

// File: rtl/hz_history.sv
module hz_history #(
  parameter int DEPTH   = 3,
  parameter int W       = 32,
  parameter int STALL_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [STALL_W-1:0]        stall,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   q
);
  logic [DEPTH-1:0][W-1:0] nxt;

  // slot k of the next state takes old slot k-1-stall, or empty
  always_comb begin
    nxt[0] = din;
    for (int k = 1; k < DEPTH; k++) begin
      nxt[k] = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j == k - 1 - int'(stall)) nxt[k] = q[j];
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)      q[g] <= '0;
      else if (en)  q[g] <= nxt[g];
    end
  end
endmodule

// File: rtl/hz_line_cross.sv
module hz_line_cross #(
  parameter int ADDR_W     = 32,
  parameter int LAST_W     = 4,
  parameter int LINE_SHIFT = 5
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LAST_W-1:0] last_reg,
  output logic [1:0]        crossings
);
  localparam int SPAN_W = LAST_W + 3;
  localparam int LINE_W = ADDR_W - LINE_SHIFT;

  logic [SPAN_W-1:0] span;
  logic [ADDR_W-1:0] tail;
  logic [LINE_W-1:0] diff;

  assign span = {1'b0, last_reg, 2'b00} + SPAN_W'(4);
  assign tail = base + ADDR_W'(span) - ADDR_W'(1);
  assign diff = tail[ADDR_W-1:LINE_SHIFT] - base[ADDR_W-1:LINE_SHIFT];
  assign crossings = (|diff[LINE_W-1:2]) ? 2'd3 : diff[1:0];
endmodule

// File: rtl/hz_cost.sv
module hz_cost
  import hz_pkg::*;
#(
  parameter int LAST_W     = 4,
  parameter int LINE_SHIFT = 5
) (
  input  hz_unit_e                          unit,
  input  logic [REG_W-1:0]                  src_reg,
  input  logic                              src_use,
  input  logic [REG_W-1:0]                  dst_reg,
  input  logic                              dst_use,
  input  logic [REG_W-1:0]                  addr_reg,
  input  logic [LAST_W-1:0]                 last_reg,
  input  logic [LINE_SHIFT-1:1]             pc_lo,
  input  logic [MOD_DEPTH-1:0][MASK_W-1:0]  mod_hist,
  input  logic [LD_DEPTH-1:0][MASK_W-1:0]   ld_hist,
  input  logic [1:0]                        crossings,
  output hz_cost_t                          cost,
  output hz_mask_t                          own_mod,
  output hz_mask_t                          own_ld
);
  function automatic logic [COST_W-1:0] load_use(
    input logic [LD_DEPTH-1:0][MASK_W-1:0] h, input logic [REG_W-1:0] r);
    if (h[0][r])      return COST_W'(3);
    else if (h[1][r]) return COST_W'(2);
    else if (h[2][r]) return COST_W'(1);
    return '0;
  endfunction

  function automatic hz_mask_t reg_write(input logic [REG_W-1:0] r);
    if (int'(r) == JUMP_BIT || int'(r) == MEMWR_BIT) return '0;
    return hz_mask_t'(1) << r;
  endfunction

  hz_mask_t          rng;
  logic [COST_W-1:0] src_c, dst_c;
  logic              pc_all_ones, pc_tail_two;
  logic              after_jump;

  always_comb begin
    for (int i = 0; i < MASK_W; i++) rng[i] = (i <= int'(last_reg));
  end

  assign src_c       = src_use ? load_use(ld_hist, src_reg) : '0;
  assign dst_c       = dst_use ? load_use(ld_hist, dst_reg) : '0;
  assign pc_all_ones = &pc_lo;
  assign pc_tail_two = (&pc_lo[LINE_SHIFT-1:2]) && !pc_lo[1];
  assign after_jump  = mod_hist[0][JUMP_BIT];

  always_comb begin
    cost    = '0;
    own_mod = '0;
    own_ld  = '0;
    case (unit)
      UC_EXEC: begin
        cost[CZ_LOADUSE] = (src_c > dst_c) ? src_c : dst_c;
        if (dst_use) own_mod = reg_write(dst_reg);
      end
      UC_MEM_RD: begin
        if (mod_hist[0][addr_reg]) cost[CZ_ADDR] = COST_W'(1);
        if (mod_hist[0][MEMWR_BIT] || mod_hist[1][MEMWR_BIT])
          cost[CZ_RAW] = COST_W'(2);
        if (dst_use) own_mod = reg_write(dst_reg);
      end
      UC_MEM_WR: begin
        if (mod_hist[0][addr_reg]) cost[CZ_ADDR] = COST_W'(1);
        own_mod[MEMWR_BIT] = 1'b1;
      end
      UC_JUMP_REG: begin
        if (mod_hist[0][src_reg])      cost[CZ_JSRC] = COST_W'(2);
        else if (mod_hist[1][src_reg]) cost[CZ_JSRC] = COST_W'(1);
        own_mod[JUMP_BIT] = 1'b1;
      end
      UC_MUL: begin
        if (mod_hist[0][src_reg] || mod_hist[0][dst_reg])
          cost[CZ_MUL] = COST_W'(1);
        own_mod = reg_write(dst_reg);
        own_mod[MOF_BIT] = 1'b1;
      end
      UC_MSTORE: begin
        if (|(mod_hist[0] & rng))      cost[CZ_MSTORE] = COST_W'(2);
        else if (|(mod_hist[1] & rng)) cost[CZ_MSTORE] = COST_W'(1);
        cost[CZ_XLINE] = COST_W'(crossings);
      end
      UC_MLOAD: begin
        cost[CZ_XLINE] = COST_W'(crossings);
        own_mod = rng;
        own_ld  = rng;
      end
      UC_IMM16: if (after_jump && pc_all_ones) cost[CZ_IMMLINE] = COST_W'(1);
      UC_IMM32: if (after_jump && pc_tail_two) cost[CZ_IMMLINE] = COST_W'(1);
      default: ;
    endcase
  end
endmodule

// File: rtl/hz_counters.sv
module hz_counters
  import hz_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  hz_cost_t                  cost,
  output logic [NCAUSE*CNT_W-1:0]   counts
);
  localparam int SUM_W = CNT_W + 1;

  for (genvar g = 0; g < NCAUSE; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    logic [SUM_W-1:0] sum;
    assign sum = {1'b0, cnt} + SUM_W'(cost[g]);
    always_ff @(posedge clk) begin
      if (rst)     cnt <= '0;
      else if (en) cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
    assign counts[g*CNT_W +: CNT_W] = cnt;
  end
endmodule

// File: rtl/hz_scoreboard.sv
module hz_scoreboard
  import hz_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int LAST_W     = 4,
  parameter int LINE_SHIFT = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      issue_valid,
  input  logic [3:0]                issue_unit,
  input  logic [REG_W-1:0]          src_reg,
  input  logic                      src_use,
  input  logic [REG_W-1:0]          dst_reg,
  input  logic                      dst_use,
  input  logic [REG_W-1:0]          addr_reg,
  input  logic [LAST_W-1:0]         last_reg,
  input  logic [ADDR_W-1:0]         xfer_addr,
  input  logic [LINE_SHIFT-1:1]     fetch_pc_lo,
  output logic                      stall_valid,
  output logic [COST_W-1:0]         stall_cycles,
  output logic [NCAUSE*CNT_W-1:0]   cause_counts
);
  logic [MOD_DEPTH-1:0][MASK_W-1:0] mod_hist;
  logic [LD_DEPTH-1:0][MASK_W-1:0]  ld_hist;
  logic [1:0]                       crossings;
  hz_cost_t                         cost;
  hz_mask_t                         own_mod, own_ld;
  logic [COST_W-1:0]                total;

  hz_line_cross #(
    .ADDR_W(ADDR_W), .LAST_W(LAST_W), .LINE_SHIFT(LINE_SHIFT)
  ) u_line (
    .base(xfer_addr), .last_reg(last_reg), .crossings(crossings)
  );

  hz_cost #(
    .LAST_W(LAST_W), .LINE_SHIFT(LINE_SHIFT)
  ) u_cost (
    .unit(hz_unit_e'(issue_unit)),
    .src_reg(src_reg), .src_use(src_use),
    .dst_reg(dst_reg), .dst_use(dst_use),
    .addr_reg(addr_reg), .last_reg(last_reg),
    .pc_lo(fetch_pc_lo),
    .mod_hist(mod_hist), .ld_hist(ld_hist),
    .crossings(crossings),
    .cost(cost), .own_mod(own_mod), .own_ld(own_ld)
  );

  always_comb begin
    total = '0;
    for (int i = 0; i < NCAUSE; i++) total = total + cost[i];
  end

  hz_history #(.DEPTH(MOD_DEPTH), .W(MASK_W), .STALL_W(COST_W)) u_mod_hist (
    .clk(clk), .rst(rst), .en(issue_valid), .stall(total),
    .din(own_mod), .q(mod_hist)
  );

  hz_history #(.DEPTH(LD_DEPTH), .W(MASK_W), .STALL_W(COST_W)) u_ld_hist (
    .clk(clk), .rst(rst), .en(issue_valid), .stall(total),
    .din(own_ld), .q(ld_hist)
  );

  hz_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(issue_valid), .cost(cost), .counts(cause_counts)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_valid  <= 1'b0;
      stall_cycles <= '0;
    end else begin
      stall_valid <= issue_valid;
      if (issue_valid) stall_cycles <= total;
    end
  end
endmodule

// File: rtl/hz_scoreboard_chk.sv
module hz_scoreboard_chk
  import hz_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LINE_SHIFT = 5
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     issue_valid,
  input logic [3:0]               issue_unit,
  input logic [LINE_SHIFT-1:1]    fetch_pc_lo,
  input logic                     stall_valid,
  input logic [COST_W-1:0]        stall_cycles,
  input logic [NCAUSE*CNT_W-1:0]  cause_counts
);
  AST_EXEC_CAP: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_unit == 4'd0) |=> stall_cycles <= 3'd3); // R1
  AST_MEMWR_CAP: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_unit == 4'd2) |=> stall_cycles <= 3'd1); // R2
  AST_RAW_ADJACENT: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_unit == 4'd1 && !$past(rst)
     && $past(issue_valid && issue_unit == 4'd2)) |=> stall_cycles >= 3'd2); // R3
  AST_IMM16_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_unit == 4'd7 && !(&fetch_pc_lo)) |=> stall_cycles == 3'd0); // R6
  AST_MLOAD_CAP: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_unit == 4'd6) |=> stall_cycles <= 3'd2); // R8
  AST_RESULT_FLAG: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> stall_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> !stall_valid); // R10
  AST_COUNTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> $stable(cause_counts)); // R11
  AST_STALL_CAP: assert property (@(posedge clk) disable iff (rst)
    stall_valid |-> stall_cycles <= 3'd4); // R10
endmodule

bind hz_scoreboard hz_scoreboard_chk #(.CNT_W(CNT_W), .LINE_SHIFT(LINE_SHIFT)) u_hz_chk (
  .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_unit(issue_unit),
  .fetch_pc_lo(fetch_pc_lo), .stall_valid(stall_valid),
  .stall_cycles(stall_cycles), .cause_counts(cause_counts)
);

// File: tb/test_hz_scoreboard.sv
module test_hz_scoreboard;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;
  localparam int U_EXEC = 0, U_RD = 1, U_WR = 2, U_JR = 3, U_MUL = 4,
                 U_MST = 5, U_MLD = 6, U_I16 = 7, U_I32 = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [3:0]  issue_unit = '0;
  logic [4:0]  src_reg = '0, dst_reg = '0, addr_reg = '0;
  logic        src_use = 1'b0, dst_use = 1'b0;
  logic [3:0]  last_reg = '0;
  logic [31:0] xfer_addr = '0;
  logic [4:1]  fetch_pc_lo = '0;
  logic        stall_valid;
  logic [2:0]  stall_cycles;
  logic [8*CW-1:0] cause_counts;

  hz_scoreboard #(.CNT_W(CW)) i_hz_scoreboard (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_unit(issue_unit),
    .src_reg(src_reg), .src_use(src_use), .dst_reg(dst_reg), .dst_use(dst_use),
    .addr_reg(addr_reg), .last_reg(last_reg), .xfer_addr(xfer_addr),
    .fetch_pc_lo(fetch_pc_lo), .stall_valid(stall_valid),
    .stall_cycles(stall_cycles), .cause_counts(cause_counts)
  );

  int total = 0, bad = 0;
  logic [1:0][31:0] mh;
  logic [2:0][31:0] vh;
  int mcnt[8];
  int ec[8];
  logic [31:0] em, ev;
  int g;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ldc(input logic [4:0] r);
    if (vh[0][r]) return 3;
    if (vh[1][r]) return 2;
    if (vh[2][r]) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] wrm(input logic [4:0] r);
    if (r == 5'd16 || r == 5'd20) return 32'd0;
    return 32'd1 << r;
  endfunction

  task automatic model_clear();
    mh = '0; vh = '0;
    for (int i = 0; i < 8; i++) mcnt[i] = 0;
  endtask

  task automatic model_eval(input int u, input logic [4:0] s, input bit su,
                            input logic [4:0] d, input bit du, input logic [4:0] a,
                            input logic [3:0] n, input logic [31:0] xa, input logic [3:0] pl);
    logic [31:0] rng, e;
    int ln, x, y;
    rng = 32'((64'd1 << (int'(n) + 1)) - 64'd1);
    e = xa + 32'(4 * (int'(n) + 1)) - 32'd1;
    ln = int'((e >> 5) - (xa >> 5));
    for (int i = 0; i < 8; i++) ec[i] = 0;
    em = '0; ev = '0;
    case (u)
      U_EXEC: begin
        x = su ? ldc(s) : 0; y = du ? ldc(d) : 0;
        ec[0] = (x > y) ? x : y;
        if (du) em = wrm(d);
      end
      U_RD: begin
        if (mh[0][a]) ec[1] = 1;
        if (mh[0][20] || mh[1][20]) ec[2] = 2;
        if (du) em = wrm(d);
      end
      U_WR: begin
        if (mh[0][a]) ec[1] = 1;
        em = 32'd1 << 20;
      end
      U_JR: begin
        ec[3] = mh[0][s] ? 2 : (mh[1][s] ? 1 : 0);
        em = 32'd1 << 16;
      end
      U_MUL: begin
        if (mh[0][s] || mh[0][d]) ec[4] = 1;
        em = wrm(d) | (32'd1 << 23);
      end
      U_MST: begin
        ec[6] = ((mh[0] & rng) != 0) ? 2 : (((mh[1] & rng) != 0) ? 1 : 0);
        ec[7] = ln;
      end
      U_MLD: begin
        ec[7] = ln; em = rng; ev = rng;
      end
      U_I16: if (mh[0][16] && pl == 4'hF) ec[5] = 1;
      U_I32: if (mh[0][16] && pl == 4'hE) ec[5] = 1;
      default: ;
    endcase
  endtask

  task automatic model_commit(input int st);
    logic [1:0][31:0] nm;
    logic [2:0][31:0] nv;
    nm[0] = em; nm[1] = (st == 0) ? mh[0] : '0;
    nv[0] = ev; nv[1] = (st == 0) ? vh[0] : '0;
    nv[2] = (st == 0) ? vh[1] : ((st == 1) ? vh[0] : '0);
    mh = nm; vh = nv;
    for (int i = 0; i < 8; i++) mcnt[i] = (mcnt[i] + ec[i] > CMAX) ? CMAX : mcnt[i] + ec[i];
  endtask

  task automatic iss(input int u, input logic [4:0] s, input bit su, input logic [4:0] d,
                     input bit du, input logic [4:0] a, input logic [3:0] n,
                     input logic [31:0] xa, input logic [3:0] pl, input string req,
                     output int got);
    int et;
    model_eval(u, s, su, d, du, a, n, xa, pl);
    et = 0;
    for (int i = 0; i < 8; i++) et += ec[i];
    issue_valid = 1'b1; issue_unit = 4'(u);
    src_reg = s; src_use = su; dst_reg = d; dst_use = du; addr_reg = a;
    last_reg = n; xfer_addr = xa; fetch_pc_lo = pl;
    @(posedge clk); @(negedge clk);
    issue_valid = 1'b0;
    got = int'(stall_cycles);
    chk(stall_valid === 1'b1 && got == et, req, got, et);
    model_commit(et);
  endtask

  task automatic nop();
    iss(U_EXEC, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 4'd0, 32'd0, 4'd0, "R10 filler", g);
  endtask

  task automatic nops(input int k);
    for (int i = 0; i < k; i++) nop();
  endtask

  task automatic chk_counts(input string req);
    for (int i = 0; i < 8; i++)
      chk(int'(cause_counts[i*CW +: CW]) == mcnt[i], req, int'(cause_counts[i*CW +: CW]), mcnt[i]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; issue_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    model_clear();
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();
    // R13: reset state
    chk(stall_valid == 1'b0, "R13 stall_valid after reset", int'(stall_valid), 0);
    chk(cause_counts == '0, "R13 counters after reset", int'(cause_counts), 0);

    // R1: load-use distance, both operands, three registers
    for (int d = 0; d <= 4; d++) begin
      for (int r = 2; r <= 5; r += 3) begin
        iss(U_MLD, 0, 0, 0, 0, 0, 4'd3, 32'd0, 0, "R8 aligned load", g);
        nops(d);
        iss(U_EXEC, 5'(r), 1'b1, 0, 0, 0, 0, 0, 0, "R1 load-use source", g);
        chk(g == ((r <= 3 && d < 3) ? 3 - d : 0), "R1 distance cost src", g,
            (r <= 3 && d < 3) ? 3 - d : 0);
        nops(3);
        iss(U_MLD, 0, 0, 0, 0, 0, 4'd3, 32'd0, 0, "R8 aligned load", g);
        nops(d);
        iss(U_EXEC, 0, 1'b0, 5'(r), 1'b1, 0, 0, 0, 0, "R1 load-use dest", g);
        nops(3);
      end
    end
    // R1: nearest producer only
    iss(U_MLD, 0, 0, 0, 0, 0, 4'd3, 32'd0, 0, "R8 load", g);
    iss(U_MLD, 0, 0, 0, 0, 0, 4'd1, 32'd0, 0, "R8 load", g);
    iss(U_EXEC, 5'd1, 1'b1, 5'd3, 1'b1, 0, 0, 0, 0, "R1 nearest producer", g);
    chk(g == 3, "R1 nearest producer value", g, 3);
    nops(3);

    // R2: address register use
    for (int d = 0; d <= 2; d++) begin
      iss(U_EXEC, 0, 0, 5'd5, 1'b1, 0, 0, 0, 0, "R2 producer", g);
      nops(d);
      iss(U_RD, 0, 0, 5'd6, 1'b1, 5'd5, 0, 0, 0, "R2 read addr", g);
      chk(g == ((d == 0) ? 1 : 0), "R2 read addr value", g, (d == 0) ? 1 : 0);
      nops(2);
    end
    iss(U_EXEC, 0, 0, 5'd5, 1'b1, 0, 0, 0, 0, "R2 producer", g);
    iss(U_WR, 0, 0, 0, 0, 5'd5, 0, 0, 0, "R2 write addr", g);
    nops(3);

    // R3: read after write window
    for (int d = 0; d <= 3; d++) begin
      iss(U_WR, 0, 0, 0, 0, 5'd9, 0, 0, 0, "R3 store", g);
      nops(d);
      iss(U_RD, 0, 0, 0, 0, 5'd9, 0, 0, 0, "R3 read", g);
      chk(g == ((d <= 1) ? 2 : 0), "R3 window value", g, (d <= 1) ? 2 : 0);
      nops(3);
    end

    // R4: jump target distance
    for (int d = 0; d <= 2; d++) begin
      iss(U_EXEC, 0, 0, 5'd7, 1'b1, 0, 0, 0, 0, "R4 producer", g);
      nops(d);
      iss(U_JR, 5'd7, 0, 0, 0, 0, 0, 0, 0, "R4 jump reg", g);
      chk(g == 2 - d, "R4 distance value", g, 2 - d);
      nops(3);
    end

    // R5: multiply operands and side register
    iss(U_EXEC, 0, 0, 5'd4, 1'b1, 0, 0, 0, 0, "R5 producer", g);
    iss(U_MUL, 5'd4, 0, 5'd6, 0, 0, 0, 0, 0, "R5 mul after write", g);
    chk(g == 1, "R5 mul value", g, 1);
    iss(U_MUL, 5'd1, 0, 5'd2, 0, 0, 0, 0, 0, "R5 mul clean", g);
    iss(U_JR, 5'd23, 0, 0, 0, 0, 0, 0, 0, "R5 side register marked", g);
    chk(g == 2, "R5 side register value", g, 2);
    nops(3);

    // R6: immediate fetch offsets after a jump and without one
    for (int p = 0; p < 16; p++) begin
      iss(U_JR, 5'd30, 0, 0, 0, 0, 0, 0, 0, "R4 jump", g);
      iss(U_I16, 0, 0, 0, 0, 0, 0, 0, 4'(p), "R6 imm16 after jump", g);
      chk(g == ((p == 15) ? 1 : 0), "R6 imm16 value", g, (p == 15) ? 1 : 0);
      iss(U_JR, 5'd30, 0, 0, 0, 0, 0, 0, 0, "R4 jump", g);
      iss(U_I32, 0, 0, 0, 0, 0, 0, 0, 4'(p), "R6 imm32 after jump", g);
      chk(g == ((p == 14) ? 1 : 0), "R6 imm32 value", g, (p == 14) ? 1 : 0);
      iss(U_I16, 0, 0, 0, 0, 0, 0, 0, 4'(p), "R6 imm16 no jump", g);
    end

    // R7: store-multiple source range
    for (int n = 0; n < 8; n++) begin
      iss(U_EXEC, 0, 0, 5'd3, 1'b1, 0, 0, 0, 0, "R7 producer", g);
      iss(U_MST, 0, 0, 0, 0, 0, 4'(n), 32'd0, 0, "R7 store adjacent", g);
      chk(g == ((n >= 3) ? 2 : 0), "R7 adjacent value", g, (n >= 3) ? 2 : 0);
      iss(U_EXEC, 0, 0, 5'd3, 1'b1, 0, 0, 0, 0, "R7 producer", g);
      nop();
      iss(U_MST, 0, 0, 0, 0, 0, 4'(n), 32'd0, 0, "R7 store gap", g);
    end
    chk_counts("R11 counters mid-run");

    // R8: line crossings, with counter saturation
    for (int xa = 0; xa < 64; xa += 4) begin
      for (int n = 0; n < 16; n++) begin
        iss(U_MLD, 0, 0, 0, 0, 0, 4'(n), 32'(xa + 32), 0, "R8 load crossings", g);
        chk(g == ((xa + 32 + 4 * n + 3) >> 5) - ((xa + 32) >> 5), "R8 crossing formula", g,
            ((xa + 32 + 4 * n + 3) >> 5) - ((xa + 32) >> 5));
      end
    end
    nops(3);
    iss(U_MST, 0, 0, 0, 0, 0, 4'd15, 32'd4, 0, "R8 store two crossings", g);
    chk(g == 2, "R8 store crossing value", g, 2);
    chk(int'(cause_counts[7*CW +: CW]) == CMAX, "R11 saturation", int'(cause_counts[7*CW +: CW]), CMAX);
    chk_counts("R11 counters after sweep");
    nops(3);

    // R9: stall cycles age the history
    iss(U_WR, 0, 0, 0, 0, 5'd9, 0, 0, 0, "R9 store", g);
    iss(U_RD, 0, 0, 0, 0, 5'd9, 0, 0, 0, "R9 read stalls", g);
    iss(U_RD, 0, 0, 0, 0, 5'd9, 0, 0, 0, "R9 read after aging", g);
    chk(g == 0, "R9 aged store value", g, 0);
    iss(U_MLD, 0, 0, 0, 0, 0, 4'd3, 32'd0, 0, "R9 load", g);
    iss(U_EXEC, 5'd0, 1'b1, 0, 0, 0, 0, 0, 0, "R9 use stalls", g);
    iss(U_EXEC, 5'd1, 1'b1, 0, 0, 0, 0, 0, 0, "R9 use after aging", g);
    chk(g == 0, "R9 aged load value", g, 0);
    nops(3);

    // R10: idle cycles do not age
    iss(U_MLD, 0, 0, 0, 0, 0, 4'd3, 32'd0, 0, "R10 load", g);
    repeat (3) @(negedge clk);
    chk(stall_valid == 1'b0, "R10 idle flag", int'(stall_valid), 0);
    iss(U_EXEC, 5'd2, 1'b1, 0, 0, 0, 0, 0, 0, "R10 use after idle", g);
    chk(g == 3, "R10 idle value", g, 3);
    nops(3);

    // R12: writes to marker indices
    iss(U_EXEC, 0, 0, 5'd16, 1'b1, 0, 0, 0, 0, "R12 write idx16", g);
    iss(U_I16, 0, 0, 0, 0, 0, 0, 0, 4'hF, "R12 no jump marker", g);
    chk(g == 0, "R12 jump marker value", g, 0);
    iss(U_EXEC, 0, 0, 5'd20, 1'b1, 0, 0, 0, 0, "R12 write idx20", g);
    iss(U_RD, 0, 0, 0, 0, 5'd9, 0, 0, 0, "R12 no store marker", g);
    chk(g == 0, "R12 store marker value", g, 0);
    chk_counts("R11 counters late");

    // R13: reset clears history and counters
    iss(U_MLD, 0, 0, 0, 0, 0, 4'd3, 32'd0, 0, "R13 load", g);
    do_reset();
    chk(cause_counts == '0, "R13 counters cleared", int'(cause_counts), 0);
    iss(U_EXEC, 5'd0, 1'b1, 0, 0, 0, 0, 0, 0, "R13 history cleared", g);
    chk(g == 0, "R13 history value", g, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule